// File: doc/BRIEF.md
# Clock-Independent Latched Event Interrupt Bank

This block watches a set of event inputs, typically power-related alarms, and records each one as a sticky interrupt flag. Each flag is set by an asynchronous set path, so an event is caught even if the bus clock is stopped or the event pulse is shorter than one clock period. Each channel has a polarity select. Software emulates edge detection by flipping that polarity after each event. Cleared flags set again at once if their input is still at the active level.

A small register port lets software:
- set the per-channel enable, polarity and mode;
- read the raw flags and the enabled (pending) flags;
- acknowledge flags with write-one-to-clear.

The raw flags reach the register file through a two-flop synchroniser. The bank drives one combined interrupt line.

The register port is a request channel and a response channel, each with valid/ready. A request moves when `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response; a write returns zero. A new request is accepted only while the response slot is empty or is being emptied in the same cycle, so `req_ready` falls whenever a response is stalled. A stalled response keeps its data unchanged until `rsp_ready` is high.

Top module: `wake_latch_irq`

## Requirements
- R1: After reset, enable, polarity and mode read as 0, raw status reads 0 while all inputs are low, `irq` is 0 and `rsp_valid` is 0.
- R2: With polarity bit 0 (active-high), a high pulse on `evt_in[n]` sets raw status bit n at byte offset 0x04. This holds for a pulse that is narrower than a clock period and falls between two clock edges. Raw status becomes readable within four clock cycles.
- R3: With polarity bit 1 (active-low) at offset 0x10, a low level on `evt_in[n]` sets raw bit n. Switching the polarity so that the present level becomes active also sets the bit.
- R4: A raw bit stays set after its input goes inactive. Writing 1 to bit n at offset 0x0C clears it, and the cleared state is visible within four cycles. Writing 0 to a bit there leaves that flag unchanged.
- R5: If the input of a channel is still active when its clear is written, the raw bit stays set.
- R6: Offset 0x08 reads raw status AND the enable register (offset 0x00).
- R7: `irq` is 1 exactly when some channel has both its raw bit and its enable bit set. Changing an enable bit never changes raw status.
- R8: The mode register at offset 0x14 stores the written value and reads it back. Writing it changes neither `irq` nor raw status.
- R9: Each accepted request yields exactly one response, in request order. `req_ready` is low while a response is stalled, and a stalled response holds its data.
- R10: Reads of the clear offset, of unmapped offsets and of unused upper bits return 0. Writes to read-only or unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | CH | Event inputs, one per channel |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | DW | Read data (0 for writes) |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker watches the port handshake on every cycle:
- a stalled response holds and blocks new requests;
- a response only appears after an accepted request.

It also checks on every cycle that a set latch stays set unless a clear pulse reaches it, and that `irq` is low whenever no channel is enabled.

Some behaviour only the bench scenarios can show:
- capture of sub-cycle pulses;
- active-low capture and re-capture after a polarity flip;
- a clear that loses against an input still active;
- the masked view and the combined line under different enable patterns;
- the inert mode register;
- response ordering under back-pressure.

// File: rtl/wli_pkg.sv
package wli_pkg;

  localparam int unsigned OFS_ENABLE = 32'h00;
  localparam int unsigned OFS_RAW    = 32'h04;
  localparam int unsigned OFS_PEND   = 32'h08;
  localparam int unsigned OFS_ACK    = 32'h0C;
  localparam int unsigned OFS_POL    = 32'h10;
  localparam int unsigned OFS_MODE   = 32'h14;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_RAW,
    SEL_PEND,
    SEL_ACK,
    SEL_POL,
    SEL_MODE,
    SEL_NONE
  } wli_sel_e;

  function automatic wli_sel_e wli_decode(input logic [31:0] byte_ofs);
    wli_sel_e s;
    case (byte_ofs)
      OFS_ENABLE: s = SEL_ENABLE;
      OFS_RAW:    s = SEL_RAW;
      OFS_PEND:   s = SEL_PEND;
      OFS_ACK:    s = SEL_ACK;
      OFS_POL:    s = SEL_POL;
      OFS_MODE:   s = SEL_MODE;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wli_chan.sv
// One event channel: a sticky flag with an asynchronous set path that needs
// no clock, and a clear that is applied on the bus clock.
module wli_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic pol_low,
  input  logic clr,
  output logic flag
);

  logic hit;

  // pol_low = 0 : active-high, pol_low = 1 : active-low
  assign hit = evt ^ pol_low;

  // The set dominates the clear, so a clear that arrives while the input
  // is still active leaves the flag set.
  always_ff @(posedge clk or negedge rst_n or posedge hit) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/wli_sync.sv
// Multi-bit two-stage synchroniser; every bit is an independent flag.
module wli_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/wli_regs.sv
// Register file behind a valid/ready request/response pair.
module wli_regs
  import wli_pkg::*;
#(
  parameter int CH = 8,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic [CH-1:0] raw,
  output logic [CH-1:0] en_q,
  output logic [CH-1:0] pol_q,
  output logic [CH-1:0] mode_q,
  output logic [CH-1:0] clr_q
);

  wli_sel_e      sel;
  logic          acc;
  logic [CH-1:0] rd_bits;

  // A slot that is empty, or drained this cycle, may take a new request.
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign sel       = wli_decode(32'(req_addr));

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_bits = en_q;
      SEL_RAW:    rd_bits = raw;
      SEL_PEND:   rd_bits = raw & en_q;
      SEL_POL:    rd_bits = pol_q;
      SEL_MODE:   rd_bits = mode_q;
      default:    rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pol_q     <= '0;
      mode_q    <= '0;
      clr_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      clr_q <= '0;
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= req_write ? '0 : DW'(rd_bits);
        if (req_write) begin
          case (sel)
            SEL_ENABLE: en_q   <= req_wdata[CH-1:0];
            SEL_ACK:    clr_q  <= req_wdata[CH-1:0];
            SEL_POL:    pol_q  <= req_wdata[CH-1:0];
            SEL_MODE:   mode_q <= req_wdata[CH-1:0];
            default:    ;
          endcase
        end
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wake_latch_irq.sv
module wake_latch_irq #(
  parameter int CH = 8,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] evt_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          irq
);

  logic [CH-1:0] en_q;
  logic [CH-1:0] pol_q;
  logic [CH-1:0] mode_q;
  logic [CH-1:0] clr_pulse;
  logic [CH-1:0] latch_q;
  logic [CH-1:0] raw_sync;

  for (genvar i = 0; i < CH; i++) begin : g_chan
    wli_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_in[i]),
      .pol_low (pol_q[i]),
      .clr     (clr_pulse[i]),
      .flag    (latch_q[i])
    );
  end

  wli_sync #(.W(CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (latch_q),
    .q     (raw_sync)
  );

  wli_regs #(.CH(CH), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .raw       (raw_sync),
    .en_q      (en_q),
    .pol_q     (pol_q),
    .mode_q    (mode_q),
    .clr_q     (clr_pulse)
  );

  assign irq = |(raw_sync & en_q);

endmodule

// File: rtl/wli_checker.sv
module wli_checker #(
  parameter int CH = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          irq,
  input logic [CH-1:0] en_q,
  input logic [CH-1:0] latch_q,
  input logic [CH-1:0] clr_pulse
);

  // R9: a stalled response keeps its data and stays valid
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: no new request is taken while a response is stalled
  a_r9_block_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9: a response only appears after an accepted request
  a_r9_rsp_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R4: a set flag survives every cycle in which no clear reaches it
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(latch_q & ~clr_pulse)) == $past(latch_q & ~clr_pulse)));

  // R7: the combined line stays low with every channel disabled
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

bind wake_latch_irq wli_checker #(.CH(CH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .en_q      (en_q),
  .latch_q   (latch_q),
  .clr_pulse (clr_pulse)
);

// File: tb/sim_wake_latch_irq.sv
`timescale 1ns/1ps
module sim_wake_latch_irq;

  localparam int CH = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [7:0] A_EN = 8'h00, A_RAW = 8'h04, A_PEND = 8'h08,
                         A_ACK = 8'h0C, A_POL = 8'h10, A_MODE = 8'h14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] evt_in = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [DW-1:0] rsp_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  int n_rsp = 0;
  bit bp_on = 1'b0;
  logic [2:0] bp_cnt = '0;

  typedef struct {
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  wake_latch_irq #(.CH(CH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  always @(posedge clk) bp_cnt <= bp_cnt + 3'd1;
  assign rsp_ready = !bp_on || (bp_cnt[1:0] == 2'b00);

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Monitor: pops the scoreboard on every response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      n_rsp++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
      end
    end
  end

  // Driver: one request, expected response pushed to the scoreboard
  task automatic xfer(input bit wr, input logic [7:0] a, input logic [DW-1:0] d,
                      input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    sb_q.push_back('{data: (wr ? '0 : exp), tag: tag});
    n_req++;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d, input string tag);
    xfer(1'b1, a, d, '0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
    xfer(1'b0, a, '0, exp, tag);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // Short pulse strictly between two clock edges
  task automatic pulse(input int ch, input logic lvl);
    @(negedge clk);
    #1 evt_in[ch] = lvl;
    #2 evt_in[ch] = ~lvl;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    check(irq == exp, tag, DW'(irq), DW'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid", DW'(rsp_valid), '0);
    chk_irq(1'b0, "R1 irq");
    rd(A_EN, 32'h0, "R1 enable");
    rd(A_POL, 32'h0, "R1 polarity");
    rd(A_MODE, 32'h0, "R1 mode");
    rd(A_RAW, 32'h0, "R1 raw");

    // R2: sub-cycle active-high pulse is captured
    pulse(3, 1'b1);
    settle();
    rd(A_RAW, 32'h08, "R2 raw after pulse ch3");
    chk_irq(1'b0, "R7 irq low while disabled");

    // R4: sticky, zero-write no effect, one-write clears
    settle();
    rd(A_RAW, 32'h08, "R4 raw still held");
    wr(A_ACK, 32'h00, "R4 ack zero write");
    settle();
    rd(A_RAW, 32'h08, "R4 zero clear ignored");
    wr(A_ACK, 32'h08, "R4 ack ch3");
    settle();
    rd(A_RAW, 32'h00, "R4 raw cleared");

    // R3: active-low; flipping polarity onto the present level sets the flag
    wr(A_POL, 32'h01, "R3 polarity write");
    settle();
    rd(A_RAW, 32'h01, "R3 flip sets ch0");
    evt_in[0] = 1'b1;
    wr(A_ACK, 32'h01, "R3 ack ch0");
    settle();
    rd(A_RAW, 32'h00, "R3 ch0 inactive high");
    pulse(0, 1'b0);
    settle();
    rd(A_RAW, 32'h01, "R3 low pulse captured");
    wr(A_ACK, 32'h01, "R3 ack ch0 again");
    settle();
    rd(A_RAW, 32'h00, "R3 cleared");
    rd(A_POL, 32'h01, "R3 polarity readback");

    // R5: clear loses against a still-active input
    evt_in[5] = 1'b1;
    settle();
    wr(A_ACK, 32'h20, "R5 ack ch5 while active");
    settle();
    rd(A_RAW, 32'h20, "R5 flag re-set");
    evt_in[5] = 1'b0;
    wr(A_ACK, 32'h20, "R5 ack ch5 inactive");
    settle();
    rd(A_RAW, 32'h00, "R5 flag cleared");

    // R6 / R7: masked view and combined interrupt
    pulse(2, 1'b1);
    pulse(6, 1'b1);
    settle();
    wr(A_EN, 32'h04, "R6 enable ch2");
    rd(A_PEND, 32'h04, "R6 masked status");
    rd(A_RAW, 32'h44, "R6 raw status");
    chk_irq(1'b1, "R7 irq high ch2 enabled");

    // R8: mode register stored, no effect
    wr(A_MODE, 32'hA5, "R8 mode write");
    rd(A_MODE, 32'hA5, "R8 mode readback");
    chk_irq(1'b1, "R8 irq unchanged by mode");
    rd(A_RAW, 32'h44, "R8 raw unchanged by mode");

    wr(A_EN, 32'h00, "R7 disable all");
    chk_irq(1'b0, "R7 irq low disabled");
    rd(A_RAW, 32'h44, "R7 raw unchanged by enable");
    wr(A_EN, 32'h40, "R7 enable ch6");
    chk_irq(1'b1, "R7 irq high ch6 enabled");
    wr(A_ACK, 32'h40, "R7 ack ch6");
    settle();
    chk_irq(1'b0, "R7 irq low after ack");
    rd(A_PEND, 32'h00, "R6 masked after ack");
    wr(A_ACK, 32'h04, "R7 ack ch2");
    settle();
    rd(A_RAW, 32'h00, "R7 all cleared");

    // R10: zero reads, upper bits, ignored writes
    rd(A_ACK, 32'h0, "R10 ack reads zero");
    rd(8'h18, 32'h0, "R10 unmapped reads zero");
    wr(A_EN, 32'hFFFF_FFFF, "R10 wide enable write");
    rd(A_EN, 32'h0000_00FF, "R10 upper bits zero");
    wr(8'h1C, 32'h0, "R10 unmapped write");
    rd(A_EN, 32'h0000_00FF, "R10 unmapped write ignored");
    wr(A_RAW, 32'hFF, "R10 raw write");
    settle();
    rd(A_RAW, 32'h00, "R10 raw is read-only");
    wr(A_EN, 32'h0, "R10 enable restore");

    // R9: ordering under back-pressure
    bp_on = 1'b1;
    rd(A_POL, 32'h01, "R9 bp polarity");
    rd(A_MODE, 32'hA5, "R9 bp mode");
    rd(A_EN, 32'h00, "R9 bp enable");
    wr(A_MODE, 32'h3C, "R9 bp mode write");
    rd(A_MODE, 32'h3C, "R9 bp mode readback");
    repeat (12) @(negedge clk);
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    check(n_req == n_rsp, "R9 one response per request", DW'(n_rsp), DW'(n_req));
    check(sb_q.size() == 0, "R9 scoreboard drained", DW'(sb_q.size()), '0);

    summary();
    $finish;
  end

endmodule